// File: doc/BRIEF.md
# Hierarchical Scan Read-Out Funnel

This block collects the scan-out bit of one addressed storage cell out of a large array and carries it to a single chip-level read-out pin. It is a tree of four-input nodes. Each node sees four data bits and four select (valid) bits from the cells or nodes beneath it. It passes up one data bit and one valid bit. A branch whose select is low contributes nothing, so the only data that reaches the root is that of the selected cell. With the default depth of two levels, one tile of 16 cells is served: four leaf nodes feed one root node.

A build-time option registers the outputs of every node. Read-out then takes one clock per tree level, and the critical path is cut at each level. Without the option, the tree is purely combinational. Every node also reports a collision when more than one of its inputs is selected, or when a child below it reported one. The collision flag travels up the tree with the same timing as the data. At the root, a two-state monitor turns this flag into a sticky fault bit. The monitor has two states. CLEAN is entered on reset. The monitor moves from CLEAN to FAULT on the first clock where the root collision flag is high. It stays in FAULT until reset.

Top module: `scanout_funnel`

## Requirements
- R1: `out_valid` is 1 exactly when at least one bit of `cell_sel` was 1 in the input cycle it corresponds to.
- R2: When exactly one bit `cell_sel[j]` is 1, `out_data` equals `cell_data[j]`, for every index j.
- R3: The data of unselected cells has no effect: `out_data` is 0 when no cell is selected, whatever `cell_data` holds, and a selected 0 reads as 0 even when every other data bit is 1.
- R4: `collide_now` is 1 exactly when two or more bits of `cell_sel` were 1. This holds whether the selected cells share a leaf node or sit in different subtrees.
- R5: `collide_sticky` becomes 1 on the clock edge after `collide_now` is first 1. It then stays 1 until reset.
- R6: With PIPELINE=1, `out_data`, `out_valid` and `collide_now` show the result for inputs applied LEVELS clock edges earlier.
- R7: With PIPELINE=0, `out_data`, `out_valid` and `collide_now` follow the inputs in the same cycle.
- R8: While `rst_n` is 0, every node register and the monitor are cleared. All outputs then read 0.
- R9: Cell j is routed through leaf node j/4, input j%4. This holds for every level of the tree, so bit j of both input buses always refers to the same cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cell_data | input | 4**LEVELS | Scan-out data bit from each cell |
| cell_sel | input | 4**LEVELS | Select (valid) bit from each cell |
| out_data | output | 1 | Data bit of the selected cell |
| out_valid | output | 1 | Some cell is selected |
| collide_now | output | 1 | More than one cell is selected |
| collide_sticky | output | 1 | A collision has been seen since reset |

## Verification
The bench builds two copies with LEVELS=2, so a full 16-cell tile is covered. One copy has PIPELINE=1 and the other has PIPELINE=0, and both see the same stimulus. The registered copy exposes the two-cycle latency and the alignment of the collision flag with the data. The combinational copy checks that the same reduction appears within one cycle. With four leaf nodes, collisions can be placed both inside one leaf and across two leaves. A walk over every cell index checks the routing of each branch.

// File: rtl/scanout_pkg.sv
package scanout_pkg;

    localparam int unsigned FANIN = 4;

    typedef enum logic {
        MON_CLEAN = 1'b0,
        MON_FAULT = 1'b1
    } mon_state_e;

    function automatic int unsigned node_total(input int unsigned levels);
        int unsigned acc;
        int unsigned width;
        acc   = 0;
        width = 1;
        for (int unsigned l = 0; l < levels; l++) begin
            acc   = acc + width;
            width = width * FANIN;
        end
        return acc;
    endfunction

endpackage

// File: rtl/so_node.sv
module so_node #(
    parameter bit PIPE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] in_data,
    input  logic [3:0] in_sel,
    input  logic [3:0] in_err,
    output logic       up_data,
    output logic       up_sel,
    output logic       up_err
);
    logic hit_c;
    logic any_c;
    logic err_c;

    always_comb begin
        hit_c = |(in_data & in_sel);
        any_c = |in_sel;
        err_c = ((in_sel & (in_sel - 4'd1)) != 4'd0) | (|in_err);
    end

    generate
        if (PIPE) begin : g_reg
            logic hit_q, any_q, err_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hit_q <= 1'b0;
                    any_q <= 1'b0;
                    err_q <= 1'b0;
                end else begin
                    hit_q <= hit_c;
                    any_q <= any_c;
                    err_q <= err_c;
                end
            end
            assign up_data = hit_q;
            assign up_sel  = any_q;
            assign up_err  = err_q;
        end else begin : g_comb
            assign up_data = hit_c;
            assign up_sel  = any_c;
            assign up_err  = err_c;
        end
    endgenerate

endmodule

// File: rtl/so_tree.sv
module so_tree #(
    parameter int unsigned LEVELS = 2,
    parameter bit          PIPE   = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [4**LEVELS-1:0]   leaf_data,
    input  logic [4**LEVELS-1:0]   leaf_sel,
    output logic                   root_data,
    output logic                   root_sel,
    output logic                   root_err
);
    import scanout_pkg::*;

    localparam int unsigned CELLS = 4 ** LEVELS;
    localparam int unsigned NODES = node_total(LEVELS);
    localparam int unsigned SLOTS = NODES + CELLS;

    // Heap layout: slot 0 is the root, slot k has children 4k+1..4k+4,
    // slots at NODES and above are the cells in index order.
    logic [SLOTS-1:0] s_data;
    logic [SLOTS-1:0] s_sel;
    logic [SLOTS-1:0] s_err;

    assign s_data[SLOTS-1:NODES] = leaf_data;
    assign s_sel[SLOTS-1:NODES]  = leaf_sel;
    assign s_err[SLOTS-1:NODES]  = '0;

    generate
        for (genvar k = 0; k < NODES; k++) begin : g_node
            so_node #(.PIPE(PIPE)) u_node (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_data (s_data[4*k+1 +: 4]),
                .in_sel  (s_sel[4*k+1 +: 4]),
                .in_err  (s_err[4*k+1 +: 4]),
                .up_data (s_data[k]),
                .up_sel  (s_sel[k]),
                .up_err  (s_err[k])
            );
        end
    endgenerate

    assign root_data = s_data[0];
    assign root_sel  = s_sel[0];
    assign root_err  = s_err[0];

endmodule

// File: rtl/so_sticky_mon.sv
module so_sticky_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    output logic fault_seen
);
    import scanout_pkg::*;

    mon_state_e state_q;
    mon_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_CLEAN: if (fault_in) state_d = MON_FAULT;
            MON_FAULT: state_d = MON_FAULT;
            default:   state_d = MON_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MON_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MON_CLEAN: fault_seen = 1'b0;
            MON_FAULT: fault_seen = 1'b1;
            default:   fault_seen = 1'b0;
        endcase
    end

endmodule

// File: rtl/scanout_funnel.sv
module scanout_funnel #(
    parameter int unsigned LEVELS   = 2,
    parameter bit          PIPELINE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [4**LEVELS-1:0] cell_data,
    input  logic [4**LEVELS-1:0] cell_sel,
    output logic                 out_data,
    output logic                 out_valid,
    output logic                 collide_now,
    output logic                 collide_sticky
);
    so_tree #(.LEVELS(LEVELS), .PIPE(PIPELINE)) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .leaf_data (cell_data),
        .leaf_sel  (cell_sel),
        .root_data (out_data),
        .root_sel  (out_valid),
        .root_err  (collide_now)
    );

    so_sticky_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_in   (collide_now),
        .fault_seen (collide_sticky)
    );

endmodule

// File: rtl/scanout_funnel_chk.sv
module scanout_funnel_chk #(
    parameter int unsigned LEVELS   = 2,
    parameter bit          PIPELINE = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [4**LEVELS-1:0] cell_data,
    input logic [4**LEVELS-1:0] cell_sel,
    input logic                 out_data,
    input logic                 out_valid,
    input logic                 collide_now,
    input logic                 collide_sticky
);
    a_r5_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        collide_sticky |=> collide_sticky);

    a_r5_sticky_sets: assert property (@(posedge clk) disable iff (!rst_n)
        collide_now |=> collide_sticky);

    a_r3_idle_data_low: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_data);

    a_r4_collide_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        collide_now |-> out_valid);

    generate
        if (!PIPELINE) begin : g_comb_chk
            a_r7_comb_valid: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == (|cell_sel));
            a_r7_comb_single: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot(cell_sel) |-> (out_data == (|(cell_data & cell_sel))));
        end
    endgenerate

endmodule

bind scanout_funnel scanout_funnel_chk #(.LEVELS(LEVELS), .PIPELINE(PIPELINE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cell_data      (cell_data),
    .cell_sel       (cell_sel),
    .out_data       (out_data),
    .out_valid      (out_valid),
    .collide_now    (collide_now),
    .collide_sticky (collide_sticky)
);

// File: tb/scanout_funnel_test.sv
module scanout_funnel_test;
    localparam int LV  = 2;
    localparam int NC  = 4 ** LV;
    localparam int LAT = LV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0] cdata = '0;
    logic [NC-1:0] csel = '0;
    logic p_d, p_v, p_e, p_s;
    logic c_d, c_v, c_e, c_s;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int q_d[$], q_v[$], q_e[$];
    int st_p = 0, st_c = 0;
    int cur_d = 0, cur_v = 0, cur_e = 0;

    always #2.5 clk = ~clk;

    scanout_funnel #(.LEVELS(LV), .PIPELINE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cell_data(cdata), .cell_sel(csel),
        .out_data(p_d), .out_valid(p_v), .collide_now(p_e), .collide_sticky(p_s));

    scanout_funnel #(.LEVELS(LV), .PIPELINE(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .cell_data(cdata), .cell_sel(csel),
        .out_data(c_d), .out_valid(c_v), .collide_now(c_e), .collide_sticky(c_s));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        q_d.delete(); q_v.delete(); q_e.delete();
        for (int i = 0; i < LAT; i++) begin
            q_d.push_back(0); q_v.push_back(0); q_e.push_back(0);
        end
        st_p = 0; st_c = 0;
    endtask

    task automatic eval(input logic [NC-1:0] d, input logic [NC-1:0] s);
        int n;
        n = 0; cur_d = 0;
        for (int i = 0; i < NC; i++) begin
            if (s[i]) begin
                n++;
                if (d[i]) cur_d = 1;
            end
        end
        cur_v = (n > 0) ? 1 : 0;
        cur_e = (n > 1) ? 1 : 0;
    endtask

    // one clock of stimulus; req names the requirement the pattern targets
    task automatic step(input logic [NC-1:0] d, input logic [NC-1:0] s, input string req);
        int ed, ev, ee;
        @(negedge clk);
        ed = q_d.pop_front(); ev = q_v.pop_front(); ee = q_e.pop_front();
        chk({"R6 ", req}, "pipe data",    int'(p_d), ed);
        chk({"R6 R1 ", req}, "pipe valid", int'(p_v), ev);
        chk({"R6 R4 ", req}, "pipe collide", int'(p_e), ee);
        chk("R5", "pipe sticky", int'(p_s), st_p);
        chk("R5", "comb sticky", int'(c_s), st_c);
        if (ee != 0) st_p = 1;
        cdata = d; csel = s;
        eval(d, s);
        q_d.push_back(cur_d); q_v.push_back(cur_v); q_e.push_back(cur_e);
        #1;
        chk({"R7 R2 ", req}, "comb data",  int'(c_d), cur_d);
        chk({"R7 R1 ", req}, "comb valid", int'(c_v), cur_v);
        chk({"R7 R4 ", req}, "comb collide", int'(c_e), cur_e);
        if (cur_e != 0) st_c = 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cdata = '0; csel = '0;
        repeat (2) @(negedge clk);
        // R8: everything reads 0 under reset
        chk("R8", "pipe data",   int'(p_d), 0);
        chk("R8", "pipe valid",  int'(p_v), 0);
        chk("R8", "pipe collide", int'(p_e), 0);
        chk("R8", "pipe sticky", int'(p_s), 0);
        chk("R8", "comb sticky", int'(c_s), 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [NC-1:0] d, s;
        model_reset();
        do_reset();
        repeat (3) step('0, '0, "R8 idle");
        // R9/R2: walk every cell with data 1 then data 0
        for (int j = 0; j < NC; j++) begin
            s = '0; s[j] = 1'b1;
            step(s, s, "R9 R2 walk one");
            step(~s, s, "R9 R3 walk zero");
        end
        // R3: nothing selected, data all ones
        repeat (3) step('1, '0, "R3 none selected");
        // R2 random single selections
        for (int k = 0; k < 200; k++) begin
            d = NC'($urandom);
            s = '0;
            if ($urandom_range(0, 3) != 0) s[$urandom_range(0, NC-1)] = 1'b1;
            step(d, s, "R2 random single");
        end
        repeat (3) step('0, '0, "idle");
        // R4: collision inside one leaf node
        step(16'h0003, 16'h0003, "R4 same leaf");
        repeat (4) step('0, '0, "R5 hold");
        // R4: collision across subtrees
        step(16'h0000, 16'h0101, "R4 cross leaf");
        for (int k = 0; k < 100; k++) begin
            d = NC'($urandom); s = NC'($urandom);
            step(d, s, "R4 random multi");
        end
        repeat (4) step('0, '0, "R5 hold");
        // R8: reset clears the sticky bit, then cross-leaf collision again
        do_reset();
        repeat (3) step('0, '0, "R8 after reset");
        step(16'h8000, 16'h8001, "R4 far cross");
        repeat (4) step('0, '0, "R5 hold");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule